// File: doc/BRIEF.md
# Switchable-length serial link packet framer and deframer

The block turns one parallel video word, an audio-channel bit and a forward-control bit into a fixed-length serial packet. It sends that packet one bit per slot of a bit-rate clock enable. A width select picks the packet length. The short packet is 24 bits and carries a 21-bit data field. The long packet is 32 bits and carries a 29-bit data field. In both formats the two sideband bits follow the data field, and a trailing bit makes the parity of the whole packet even.

A companion deframer takes the serial bits back in. A packet-start pulse aligns it to the packet. When the last bit arrives it rebuilds the data word and the two sideband bits, and it flags a parity mismatch. Both halves run on one clock, each with its own slot enable. A system wires the framer's bit, start marker and length marker into the deframer, either directly or through a link.

Top module: `lpk_codec`

## Requirements
- R1: When `wide_sel` is 1 a packet is 32 bit slots long; when it is 0 a packet is 24 bit slots long. The `ser_sof` marker rises once per packet, so consecutive rises are exactly that many slots apart.
- R2: The packet is sent least significant bit first. Packet bit n, for n below the field width (21 short, 29 long), equals `tx_data[n]`, and the deframer returns it on `rx_data[n]`.
- R3: In the short format `tx_data[28:21]` has no effect on the packet, and `rx_data[28:21]` reads zero.
- R4: The audio-channel bit sits at packet position 21 (short) or 29 (long). The forward-control bit sits at the next position up (22 or 30). The deframer returns them on `rx_acb` and `rx_fcc`.
- R5: The final bit (23 short, 31 long) is the XOR of every earlier packet bit, so every packet has even parity.
- R6: `ser_out` and `ser_sof` change only on a clock edge at which `bit_en` is 1. Each slot lasts from one enabled edge to the next.
- R7: The data, sideband and width inputs are captured only at the enabled edge that starts a packet. Changing them mid-packet alters neither that packet nor its length, and `ser_wide` stays constant for the whole packet.
- R8: `ser_sof` is 1 exactly during the slot that carries packet bit 0.
- R9: The deframer begins a packet when `rx_start` is 1 at an edge where `rx_bit_en` is 1. That bit is packet bit 0, and `rx_wide` sampled at that edge sets the expected length.
- R10: `rx_valid` is a one-cycle pulse in the cycle after the edge that samples the last packet bit. `rx_data`, `rx_acb` and `rx_fcc` hold the rebuilt fields from that cycle on.
- R11: `rx_perr` is 1 together with `rx_valid` when the received packet has odd parity, and is 0 at all other times.
- R12: While `rst` is 1, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for both halves |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Framer slot enable, one pulse per serial bit |
| wide_sel | input | 1 | 1 selects the 32-bit packet, 0 the 24-bit packet |
| tx_data | input | 29 | Parallel data word to send |
| tx_acb | input | 1 | Audio-channel bit to send |
| tx_fcc | input | 1 | Forward-control bit to send |
| ser_out | output | 1 | Serial packet bit |
| ser_sof | output | 1 | High during the bit-0 slot |
| ser_wide | output | 1 | Length of the packet being sent |
| rx_bit_en | input | 1 | Deframer slot enable |
| rx_bit | input | 1 | Serial bit into the deframer |
| rx_start | input | 1 | Marks the incoming bit as packet bit 0 |
| rx_wide | input | 1 | Length of the incoming packet, sampled with the start |
| rx_valid | output | 1 | One-cycle pulse when a packet is rebuilt |
| rx_data | output | 29 | Rebuilt data word |
| rx_acb | output | 1 | Rebuilt audio-channel bit |
| rx_fcc | output | 1 | Rebuilt forward-control bit |
| rx_perr | output | 1 | Parity mismatch, qualified by `rx_valid` |

## Verification
Bit 0 appears on `ser_out`, with `ser_sof` high, in the cycle after the enabled edge that loads the packet. The next rise of `ser_sof` follows exactly one packet length of enabled slots later. The deframer samples the last bit on that same edge, so `rx_valid` and the rebuilt fields are due in the cycle where the next marker rises. The bench samples at the falling edge and counts cycles from each marker rise. Every bit, the length, the valid pulse and the rebuilt fields are checked at the cycle derived that way. With a slowed enable, it confirms that the serial output holds across the idle edges and that the period stretches to three cycles per slot.

// File: rtl/lpk_pkg.sv
package lpk_pkg;
  parameter int unsigned LPK_DW_NARROW = 21;
  parameter int unsigned LPK_DW_WIDE   = 29;
  localparam int unsigned SIDE_BITS    = 3;

  typedef struct packed {
    logic acb;
    logic fcc;
  } side_t;
endpackage

// File: rtl/lpk_pack.sv
module lpk_pack
  import lpk_pkg::*;
#(
  parameter int unsigned DW_N = LPK_DW_NARROW,
  parameter int unsigned DW_W = LPK_DW_WIDE,
  localparam int unsigned PKT_W = DW_W + SIDE_BITS
) (
  input  logic             wide,
  input  logic [DW_W-1:0]  data,
  input  side_t            side,
  output logic [PKT_W-1:0] pkt
);
  logic [DW_W-1:0] fld;
  logic            par;

  // upper field bits are forced low in the short format
  generate
    for (genvar i = 0; i < DW_W; i++) begin : g_fld
      if (i < DW_N) begin : g_lo
        assign fld[i] = data[i];
      end else begin : g_hi
        assign fld[i] = wide & data[i];
      end
    end
  endgenerate

  assign par = (^fld) ^ side.acb ^ side.fcc;

  always_comb begin
    pkt = '0;
    pkt[DW_W-1:0] = fld;
    if (wide) begin
      pkt[DW_W]     = side.acb;
      pkt[DW_W+1]   = side.fcc;
      pkt[DW_W+2]   = par;
    end else begin
      pkt[DW_N]     = side.acb;
      pkt[DW_N+1]   = side.fcc;
      pkt[DW_N+2]   = par;
    end
  end
endmodule

// File: rtl/lpk_framer.sv
module lpk_framer
  import lpk_pkg::*;
#(
  parameter int unsigned DW_N = LPK_DW_NARROW,
  parameter int unsigned DW_W = LPK_DW_WIDE,
  localparam int unsigned PKT_W = DW_W + SIDE_BITS,
  localparam int unsigned PKT_N = DW_N + SIDE_BITS,
  localparam int unsigned CW    = $clog2(PKT_W)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bit_en,
  input  logic            wide_sel,
  input  logic [DW_W-1:0] data,
  input  side_t           side,
  output logic            ser_out,
  output logic            ser_sof,
  output logic            ser_wide
);
  logic [PKT_W-1:0] pkt;
  logic [PKT_W-1:0] shreg;
  logic [CW-1:0]    slot_left;
  logic             load;

  lpk_pack #(.DW_N(DW_N), .DW_W(DW_W)) u_pack (
    .wide (wide_sel),
    .data (data),
    .side (side),
    .pkt  (pkt)
  );

  assign load = bit_en && (slot_left == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg     <= '0;
      slot_left <= '0;
      ser_out   <= 1'b0;
      ser_sof   <= 1'b0;
      ser_wide  <= 1'b0;
    end else if (bit_en) begin
      ser_sof <= load;
      if (load) begin
        ser_out   <= pkt[0];
        shreg     <= pkt >> 1;
        slot_left <= wide_sel ? CW'(PKT_W - 1) : CW'(PKT_N - 1);
        ser_wide  <= wide_sel;
      end else begin
        ser_out   <= shreg[0];
        shreg     <= shreg >> 1;
        slot_left <= slot_left - 1'b1;
      end
    end
  end

  AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !bit_en |=> ($stable(ser_out) && $stable(ser_sof))); // R6
  AST_MODE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
    !(bit_en && slot_left == '0) |=> $stable(ser_wide)); // R7
  AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (rst)
    slot_left <= (ser_wide ? CW'(PKT_W - 1) : CW'(PKT_N - 1))); // R1
endmodule

// File: rtl/lpk_deframer.sv
module lpk_deframer
  import lpk_pkg::*;
#(
  parameter int unsigned DW_N = LPK_DW_NARROW,
  parameter int unsigned DW_W = LPK_DW_WIDE,
  localparam int unsigned PKT_W = DW_W + SIDE_BITS,
  localparam int unsigned PKT_N = DW_N + SIDE_BITS,
  localparam int unsigned CW    = $clog2(PKT_W)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bit_en,
  input  logic            bit_in,
  input  logic            start,
  input  logic            wide,
  output logic            valid,
  output logic [DW_W-1:0] data,
  output side_t           side,
  output logic            perr
);
  logic [PKT_W-1:0] acc;
  logic [PKT_W-1:0] full;
  logic [CW-1:0]    pos;
  logic             busy;
  logic             mode_q;
  logic             par_q;
  logic             last;

  assign last = (pos == (mode_q ? CW'(PKT_W - 1) : CW'(PKT_N - 1)));

  always_comb begin
    full = acc | (PKT_W'(bit_in) << pos);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc    <= '0;
      pos    <= '0;
      busy   <= 1'b0;
      mode_q <= 1'b0;
      par_q  <= 1'b0;
      valid  <= 1'b0;
      perr   <= 1'b0;
      data   <= '0;
      side   <= '0;
    end else begin
      valid <= 1'b0;
      perr  <= 1'b0;
      if (bit_en) begin
        if (start) begin
          acc    <= PKT_W'(bit_in);
          par_q  <= bit_in;
          pos    <= CW'(1);
          mode_q <= wide;
          busy   <= 1'b1;
        end else if (busy) begin
          acc   <= full;
          par_q <= par_q ^ bit_in;
          if (last) begin
            busy  <= 1'b0;
            valid <= 1'b1;
            perr  <= par_q ^ bit_in;
            if (mode_q) begin
              data     <= full[DW_W-1:0];
              side.acb <= full[DW_W];
              side.fcc <= full[DW_W+1];
            end else begin
              data     <= DW_W'(full[DW_N-1:0]);
              side.acb <= full[DW_N];
              side.fcc <= full[DW_N+1];
            end
          end else begin
            pos <= pos + 1'b1;
          end
        end
      end
    end
  end

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    valid |=> !valid); // R10
  AST_PERR_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
    perr |-> valid); // R11
  AST_SHORT_TOP_ZERO: assert property (@(posedge clk) disable iff (rst)
    (valid && !mode_q) |-> (data[DW_W-1:DW_N] == '0)); // R3
endmodule

// File: rtl/lpk_codec.sv
module lpk_codec
  import lpk_pkg::*;
#(
  parameter int unsigned DW_N = LPK_DW_NARROW,
  parameter int unsigned DW_W = LPK_DW_WIDE
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bit_en,
  input  logic            wide_sel,
  input  logic [DW_W-1:0] tx_data,
  input  logic            tx_acb,
  input  logic            tx_fcc,
  output logic            ser_out,
  output logic            ser_sof,
  output logic            ser_wide,
  input  logic            rx_bit_en,
  input  logic            rx_bit,
  input  logic            rx_start,
  input  logic            rx_wide,
  output logic            rx_valid,
  output logic [DW_W-1:0] rx_data,
  output logic            rx_acb,
  output logic            rx_fcc,
  output logic            rx_perr
);
  side_t tx_side;
  side_t rx_side;

  assign tx_side.acb = tx_acb;
  assign tx_side.fcc = tx_fcc;
  assign rx_acb      = rx_side.acb;
  assign rx_fcc      = rx_side.fcc;

  lpk_framer #(.DW_N(DW_N), .DW_W(DW_W)) u_framer (
    .clk      (clk),
    .rst      (rst),
    .bit_en   (bit_en),
    .wide_sel (wide_sel),
    .data     (tx_data),
    .side     (tx_side),
    .ser_out  (ser_out),
    .ser_sof  (ser_sof),
    .ser_wide (ser_wide)
  );

  lpk_deframer #(.DW_N(DW_N), .DW_W(DW_W)) u_deframer (
    .clk    (clk),
    .rst    (rst),
    .bit_en (rx_bit_en),
    .bit_in (rx_bit),
    .start  (rx_start),
    .wide   (rx_wide),
    .valid  (rx_valid),
    .data   (rx_data),
    .side   (rx_side),
    .perr   (rx_perr)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!rx_valid && !rx_perr && !ser_sof)); // R12
endmodule

// File: tb/lpk_codec_tb.sv
module lpk_codec_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bit_en;
  logic        wide_sel = 1'b0;
  logic [28:0] tx_data = '0;
  logic        tx_acb = 1'b0;
  logic        tx_fcc = 1'b0;
  logic        ser_out, ser_sof, ser_wide;
  logic        flip = 1'b0;
  logic        rx_bit;
  logic        rx_valid, rx_acb, rx_fcc, rx_perr;
  logic [28:0] rx_data;

  int checks = 0;
  int errors = 0;
  int div = 1;
  int dcnt;

  always #5 clk = ~clk;

  assign rx_bit = ser_out ^ flip;

  lpk_codec dut_i (
    .clk(clk), .rst(rst), .bit_en(bit_en), .wide_sel(wide_sel),
    .tx_data(tx_data), .tx_acb(tx_acb), .tx_fcc(tx_fcc),
    .ser_out(ser_out), .ser_sof(ser_sof), .ser_wide(ser_wide),
    .rx_bit_en(bit_en), .rx_bit(rx_bit), .rx_start(ser_sof), .rx_wide(ser_wide),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_acb(rx_acb), .rx_fcc(rx_fcc),
    .rx_perr(rx_perr)
  );

  // slot enable: one pulse every div cycles
  always @(posedge clk) begin
    if (rst) begin
      dcnt   <= 0;
      bit_en <= 1'b0;
    end else begin
      dcnt   <= (dcnt >= div - 1) ? 0 : dcnt + 1;
      bit_en <= (dcnt == 0);
    end
  end

  // {wide, acb, fcc, data[28:0]}
  localparam logic [31:0] VEC [6] = '{
    32'hD234_5678, 32'h3FFF_FFFF, 32'h8000_0000,
    32'h600A_5A5A, 32'hBFFF_FFFF, 32'h0015_5555
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_pkt(input logic w, input logic [28:0] d,
                                          input logic a, input logic f);
    logic [31:0] p;
    int n;
    n = w ? 29 : 21;
    p = '0;
    for (int i = 0; i < n; i++) p[i] = d[i];
    p[n]     = a;
    p[n + 1] = f;
    p[n + 2] = ^p;
    return p;
  endfunction

  function automatic logic [28:0] exp_data(input logic w, input logic [28:0] d);
    return w ? d : {8'b0, d[20:0]};
  endfunction

  task automatic wait_rise();
    logic last;
    last = ser_sof;
    forever begin
      @(negedge clk);
      if (ser_sof && !last) break;
      last = ser_sof;
    end
  endtask

  task automatic drive(input logic [31:0] e);
    wide_sel = e[31];
    tx_acb   = e[30];
    tx_fcc   = e[29];
    tx_data  = e[28:0];
  endtask

  logic [31:0] got;
  logic        bad;
  int          len;
  int          k;

  initial begin
    repeat (3) @(negedge clk);
    chk("R12 reset outputs",
        32'({ser_out, ser_sof, ser_wide, rx_valid, rx_perr, rx_acb, rx_fcc}), 32'd0);
    chk("R12 reset rx_data", 32'(rx_data), 32'd0);
    rst = 1'b0;

    // table walk with one slot per cycle
    for (int v = 0; v < 6; v++) begin
      logic [31:0] e;
      e = VEC[v];
      wait_rise();
      drive(e);
      wait_rise();
      len = e[31] ? 32 : 24;
      got = '0;
      bad = 1'b0;
      for (int b = 0; b < len; b++) begin
        got[b] = ser_out;
        if (b > 0 && (rx_valid || ser_sof)) bad = 1'b1;
        @(negedge clk);
      end
      chk("R2 R4 R5 serial packet bits", got, exp_pkt(e[31], e[28:0], e[30], e[29]));
      chk("R1 R8 next start after packet length", 32'(ser_sof), 32'd1);
      chk("R10 valid only after last bit", 32'({bad, rx_valid}), 32'd1);
      chk("R2 R3 rebuilt data", 32'(rx_data), 32'(exp_data(e[31], e[28:0])));
      chk("R4 rebuilt sideband", 32'({rx_acb, rx_fcc}), 32'({e[30], e[29]}));
      chk("R11 clean packet parity", 32'(rx_perr), 32'd0);
      @(negedge clk);
      chk("R10 valid lasts one cycle", 32'(rx_valid), 32'd0);
    end

    // R7: mid-packet change of width and data
    wait_rise();
    drive(32'hC765_4321);
    wait_rise();
    bad = 1'b0;
    k = 0;
    forever begin
      @(negedge clk);
      k++;
      if (k == 5) drive(32'h0000_0FFF);
      if (ser_sof) break;
      if (ser_wide !== 1'b1) bad = 1'b1;
    end
    chk("R7 length kept after mid-packet width change", 32'(k), 32'd32);
    chk("R7 width marker stable", 32'(bad), 32'd0);
    chk("R7 mid-packet data change ignored", 32'(rx_data), 32'h0765_4321);
    k = 0;
    forever begin
      @(negedge clk);
      k++;
      if (ser_sof) break;
    end
    chk("R1 new width from next boundary", 32'(k), 32'd24);
    chk("R3 short format top bits zero", 32'(rx_data), 32'h0000_0FFF);

    // R11: injected bit error
    drive(32'h0012_3456);
    wait_rise();
    wait_rise();
    repeat (3) @(negedge clk);
    flip = 1'b1;
    @(negedge clk);
    flip = 1'b0;
    repeat (20) @(negedge clk);
    chk("R11 parity error flagged", 32'({rx_valid, rx_perr}), 32'd3);
    chk("R9 corrupted bit lands at its position", 32'(rx_data), 32'h0012_345E);
    repeat (24) @(negedge clk);
    chk("R11 error clears on clean packet", 32'({rx_valid, rx_perr}), 32'd2);

    // R6: slot enable every third cycle
    div = 3;
    drive(32'hA0AB_CDEF);
    wait_rise();
    wait_rise();
    bad = 1'b0;
    k = 0;
    got = '0;
    forever begin
      logic en_next, prev, lastsof;
      en_next = bit_en;
      prev    = ser_out;
      lastsof = ser_sof;
      @(negedge clk);
      k++;
      if (!en_next && ser_out !== prev) bad = 1'b1;
      if (rx_valid) got = 32'(rx_data) | 32'h8000_0000;
      if (ser_sof && !lastsof) break;
    end
    chk("R6 packet spans slots not cycles", 32'(k), 32'd96);
    chk("R6 output holds between enables", 32'(bad), 32'd0);
    chk("R6 slow-enable data rebuilt", got, 32'h8000_0000 | 32'h00AB_CDEF);
    div = 1;

    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R12 reset mid-run", 32'({ser_out, ser_sof, ser_wide, rx_valid, rx_perr}), 32'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule